// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides, for each received frame, whether its 48-bit destination address should be let through. It sorts the address into one of three kinds (unicast, multicast or broadcast) and applies the rule for that kind. Unicast must match the programmed station address exactly. Broadcast depends on one enable bit. Multicast depends on an enable bit and on one bit of a 64-entry hash table. A promiscuous enable overrides all of these rules and lets every frame through.

The receive path places the address on `da` together with a one-cycle `da_valid` strobe. One cycle later the block returns the decision, the address kind and the 6-bit table index, with `res_valid` marking that cycle. Software programs the configuration through a simple write port. Select 0 holds the receive-config word. Select 1 holds the low hash word and select 2 the high hash word. Select 3 holds the low 32 bits of the station address and select 4 the upper 16 bits.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_SHOW` means a result is on the outputs. The transition IDLE->SHOW is taken on a strobe. SHOW->SHOW is taken on a back-to-back strobe. SHOW->IDLE and IDLE->IDLE are taken when there is no strobe.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is held and after it is released, `res_valid`, `res_accept`, `res_hash` and `res_kind` are all 0, and every configuration register is 0.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `da_valid` is high, including on back-to-back strobes, and is low otherwise.
- R3: `res_hash` is the low 6 bits of an XOR over the six address bytes, where byte k is `da[47-8k -: 8]`. Bytes 0 and 3 each give (b>>2)^(b<<4), bytes 1 and 4 each give (b>>4)^(b<<2), and bytes 2 and 5 each give (b>>6)^b. The hash is reported for every kind of address.
- R4: A table index below 32 selects that bit of the low hash word (select 1). An index of 32 or above selects bit (index-32) of the high hash word (select 2).
- R5: An all-ones address has kind 2. It is accepted if and only if bit 13 of the config word is set, and the hash table is not consulted.
- R6: Any other address with `da[40]`=1 has kind 1. It is accepted if and only if bit 5 of the config word is set and its table bit is 1. With both hash words all ones, every such address is accepted.
- R7: An address with `da[40]`=0 has kind 0. It is accepted only when all 48 bits equal the station address, where select 3 data gives `da[31:0]` and select 4 data[15:0] gives `da[47:32]`.
- R8: When bit 21 of the config word is set, every address is accepted, and its kind and hash are still reported.
- R9: In a cycle that follows no strobe, `res_accept`, `res_hash` and `res_kind` keep their previous values.
- R10: A register write takes effect for strobes from the next cycle onward. A write in the same cycle as a strobe does not affect that strobe's result. Writes to selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select |
| cfg_wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Result present |
| res_accept | output | 1 | 1 = frame passes the filter |
| res_hash | output | 6 | Computed table index |
| res_kind | output | 2 | 0 unicast, 1 multicast, 2 broadcast |

## Verification
Every result is due one clock edge after its strobe. A configuration write first changes the outcome for a strobe placed one edge after the write. The bench drives on the falling edge, so each input crosses exactly one rising edge before the next falling edge. The bench's reference model updates its expectation and its configuration mirror at that same rising edge. At every falling edge the bench compares all four outputs with the model, so both the due cycle and the hold behaviour between results are checked. Directed checks confirm the same-cycle write case, the upper half of the hash table and the precedence of broadcast over the hash.

// File: rtl/filt_pkg.sv
package filt_pkg;
    localparam int ADDR_W   = 48;
    localparam int WORD_W   = 32;
    localparam int TBL_W    = 64;
    localparam int IDX_W    = $clog2(TBL_W);
    localparam int SEL_W    = 3;

    localparam int PROMISC_BIT = 21;
    localparam int BCAST_BIT   = 13;
    localparam int MCAST_BIT   = 5;

    localparam logic [SEL_W-1:0] SEL_CFG    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_HASHLO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HASHHI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STA_LO = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STA_HI = 3'd4;

    typedef enum logic [1:0] {
        KIND_UNI   = 2'd0,
        KIND_MULTI = 2'd1,
        KIND_BCAST = 2'd2
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fstate_e;
endpackage

// File: rtl/filt_cfg_regs.sv
module filt_cfg_regs
    import filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 promisc_en,
    output logic                 bcast_en,
    output logic                 mcast_en,
    output logic [TBL_W-1:0]     hash_tbl,
    output logic [ADDR_W-1:0]    station
);
    localparam int STA_HI_W = ADDR_W - WORD_W;

    logic [WORD_W-1:0]   tbl_lo, tbl_hi, sta_lo;
    logic [STA_HI_W-1:0] sta_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            promisc_en <= 1'b0;
            bcast_en   <= 1'b0;
            mcast_en   <= 1'b0;
            tbl_lo     <= '0;
            tbl_hi     <= '0;
            sta_lo     <= '0;
            sta_hi     <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CFG: begin
                    promisc_en <= wr_data[PROMISC_BIT];
                    bcast_en   <= wr_data[BCAST_BIT];
                    mcast_en   <= wr_data[MCAST_BIT];
                end
                SEL_HASHLO: tbl_lo <= wr_data;
                SEL_HASHHI: tbl_hi <= wr_data;
                SEL_STA_LO: sta_lo <= wr_data;
                SEL_STA_HI: sta_hi <= wr_data[STA_HI_W-1:0];
                default: ;
            endcase
        end
    end

    assign hash_tbl = {tbl_hi, tbl_lo};
    assign station  = {sta_hi, sta_lo};

    // R10
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_STA_HI) |=> ($stable(hash_tbl) && $stable(station)
            && $stable(promisc_en) && $stable(bcast_en) && $stable(mcast_en)));
endmodule

// File: rtl/mac_hash_fold.sv
module mac_hash_fold
    import filt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int N_BYTES = ADDR_W / 8;
    localparam int CW      = 12;

    logic [CW-1:0] contrib [N_BYTES];
    logic [CW-1:0] folded;

    for (genvar gi = 0; gi < N_BYTES; gi++) begin : g_byte
        logic [CW-1:0] ext;
        assign ext = {{(CW-8){1'b0}}, addr[ADDR_W-1-8*gi -: 8]};
        if (gi % 3 == 0) begin : g_pos_a
            assign contrib[gi] = (ext >> 2) ^ (ext << 4);
        end else if (gi % 3 == 1) begin : g_pos_b
            assign contrib[gi] = (ext >> 4) ^ (ext << 2);
        end else begin : g_pos_c
            assign contrib[gi] = (ext >> 6) ^ ext;
        end
    end

    always_comb begin
        folded = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            folded = folded ^ contrib[k];
        end
    end

    assign idx = folded[IDX_W-1:0];
endmodule

// File: rtl/filt_classify.sv
module filt_classify
    import filt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TBL_W-1:0]  hash_tbl,
    input  logic [ADDR_W-1:0] station,
    input  logic              promisc_en,
    input  logic              bcast_en,
    input  logic              mcast_en,
    output kind_e             kind,
    output logic              accept
);
    logic is_bcast, is_group, tbl_hit;

    assign is_bcast = &addr;
    assign is_group = addr[ADDR_W-8];
    assign tbl_hit  = hash_tbl[idx];

    always_comb begin
        if (is_bcast)      kind = KIND_BCAST;
        else if (is_group) kind = KIND_MULTI;
        else               kind = KIND_UNI;
    end

    always_comb begin
        if (promisc_en) begin
            accept = 1'b1;
        end else begin
            unique case (kind)
                KIND_BCAST: accept = bcast_en;
                KIND_MULTI: accept = mcast_en & tbl_hit;
                default:    accept = (addr == station);
            endcase
        end
    end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import filt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [2:0]         cfg_wr_sel,
    input  logic [31:0]        cfg_wr_data,
    input  logic               da_valid,
    input  logic [47:0]        da,
    output logic               res_valid,
    output logic               res_accept,
    output logic [5:0]         res_hash,
    output logic [1:0]         res_kind
);
    logic              cfg_promisc, cfg_bcast, cfg_mcast;
    logic [TBL_W-1:0]  cfg_tbl;
    logic [ADDR_W-1:0] cfg_station;
    logic [IDX_W-1:0]  hash_now;
    kind_e             kind_now;
    logic              accept_now;
    fstate_e           state, state_nx;

    filt_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .promisc_en (cfg_promisc),
        .bcast_en   (cfg_bcast),
        .mcast_en   (cfg_mcast),
        .hash_tbl   (cfg_tbl),
        .station    (cfg_station)
    );

    mac_hash_fold u_fold (
        .addr (da),
        .idx  (hash_now)
    );

    filt_classify u_cls (
        .addr       (da),
        .idx        (hash_now),
        .hash_tbl   (cfg_tbl),
        .station    (cfg_station),
        .promisc_en (cfg_promisc),
        .bcast_en   (cfg_bcast),
        .mcast_en   (cfg_mcast),
        .kind       (kind_now),
        .accept     (accept_now)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = da_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = da_valid ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_accept <= 1'b0;
            res_hash   <= '0;
            res_kind   <= KIND_UNI;
        end else if (da_valid) begin
            res_accept <= accept_now;
            res_hash   <= hash_now;
            res_kind   <= kind_now;
        end
    end

    assign res_valid = (state == ST_SHOW);

    // R2
    result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid);

    // R8
    promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && cfg_promisc) |=> res_accept);

    // R5
    bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (&da) && !cfg_promisc && !cfg_bcast) |=>
            (!res_accept && res_kind == 2'd2));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> ($stable(res_hash) && $stable(res_accept) && $stable(res_kind)));
endmodule

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, res_accept;
    logic [5:0]  res_hash;
    logic [1:0]  res_kind;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dest_addr_filter u_dest_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .da_valid(da_valid), .da(da),
        .res_valid(res_valid), .res_accept(res_accept), .res_hash(res_hash),
        .res_kind(res_kind)
    );

    // reference model state
    logic        m_prom = 0, m_bc = 0, m_mc = 0;
    logic [63:0] m_tbl = '0;
    logic [47:0] m_sta = '0;
    logic        e_valid = 0, e_acc = 0;
    int          e_hash = 0, e_kind = 0;
    string       e_tag = "R1";

    function automatic int ref_hash(logic [47:0] a);
        int h = 0;
        for (int i = 0; i < 6; i++) begin
            int b = int'((a >> (40 - 8 * i)) & 48'hFF);
            case (i % 3)
                0: h = h ^ ((b >> 2) ^ (b << 4));
                1: h = h ^ ((b >> 4) ^ (b << 2));
                default: h = h ^ ((b >> 6) ^ b);
            endcase
        end
        return h % 64;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 0; e_acc <= 0; e_hash <= 0; e_kind <= 0; e_tag <= "R1";
            m_prom <= 0; m_bc <= 0; m_mc <= 0; m_tbl <= '0; m_sta <= '0;
        end else begin
            e_valid <= da_valid;
            if (da_valid) begin
                int h;
                h = ref_hash(da);
                e_hash <= h;
                if (da == {48{1'b1}}) begin
                    e_kind <= 2; e_acc <= m_prom | m_bc; e_tag <= m_prom ? "R8" : "R5";
                end else if (da[40]) begin
                    e_kind <= 1; e_acc <= m_prom | (m_mc & m_tbl[h]); e_tag <= m_prom ? "R8" : "R6";
                end else begin
                    e_kind <= 0; e_acc <= m_prom | (da == m_sta); e_tag <= m_prom ? "R8" : "R7";
                end
            end else begin
                e_tag <= "R9";
            end
            if (cfg_wr_en) begin
                case (cfg_wr_sel)
                    3'd0: begin m_prom <= cfg_wr_data[21]; m_bc <= cfg_wr_data[13]; m_mc <= cfg_wr_data[5]; end
                    3'd1: m_tbl[31:0]  <= cfg_wr_data;
                    3'd2: m_tbl[63:32] <= cfg_wr_data;
                    3'd3: m_sta[31:0]  <= cfg_wr_data;
                    3'd4: m_sta[47:32] <= cfg_wr_data[15:0];
                    default: ;
                endcase
            end
        end
    end

    // every-clock comparison
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (res_valid !== e_valid) begin
                errors++;
                $display("FAIL R2 res_valid actual %0b expected %0b", res_valid, e_valid);
            end
            checks++;
            if (res_accept !== e_acc) begin
                errors++;
                $display("FAIL %s res_accept actual %0b expected %0b", e_tag, res_accept, e_acc);
            end
            checks++;
            if (int'(res_hash) != e_hash) begin
                errors++;
                $display("FAIL R3 res_hash actual %0d expected %0d", res_hash, e_hash);
            end
            checks++;
            if (int'(res_kind) != e_kind) begin
                errors++;
                $display("FAIL %s res_kind actual %0d expected %0d", e_tag, res_kind, e_kind);
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_sel = s; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic send(input logic [47:0] a);
        @(negedge clk);
        da_valid = 1; da = a;
        @(negedge clk);
        da_valid = 0;
    endtask

    task automatic expect_acc(input string tag, input logic exp);
        checks++;
        if (res_accept !== exp) begin
            errors++;
            $display("FAIL %s directed accept actual %0b expected %0b", tag, res_accept, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual hung expected finished");
        finish_run();
    end

    localparam logic [47:0] STA = 48'h0211_2233_4455;
    localparam logic [47:0] BC  = {48{1'b1}};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        checks++;
        if (res_valid !== 0 || res_accept !== 0 || res_hash !== 0 || res_kind !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b%0b/%0d/%0d expected 00/0/0",
                     res_valid, res_accept, res_hash, res_kind);
        end
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R7 unicast
        wr(3'd3, STA[31:0]);
        wr(3'd4, {16'h0, STA[47:32]});
        send(STA);                       expect_acc("R7", 1);
        send(STA ^ 48'h0000_0000_0100);  expect_acc("R7", 0);
        send(STA ^ 48'h0100_0000_0000);  expect_acc("R7", 0);

        // R5 broadcast with precedence over hash
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_0020);
        send(BC);                        expect_acc("R5", 0);
        wr(3'd0, 32'h0000_2000);
        send(BC);                        expect_acc("R5", 1);

        // R6 all-ones table accepts all multicast
        wr(3'd0, 32'h0000_0020);
        send(48'h0100_5E00_0001);        expect_acc("R6", 1);
        send(48'h3333_0000_00FB);        expect_acc("R6", 1);
        wr(3'd0, 32'h0);
        send(48'h0100_5E00_0001);        expect_acc("R6", 0);
        wr(3'd0, 32'h0000_0020);

        // R4 single-bit tables over a sweep of group addresses
        for (int k = 0; k < 24; k++) begin
            logic [47:0] a;
            int h;
            logic [63:0] one;
            a = {8'h01, 8'h00, 8'h5E, 8'(8'h10 + 7 * k), 8'(8'h20 ^ k), 8'(8'h31 + 13 * k)};
            h = ref_hash(a);
            one = 64'd1 << h;
            wr(3'd1, one[31:0]);
            wr(3'd2, one[63:32]);
            send(a);                     expect_acc("R4", 1);
            wr(3'd1, ~one[31:0]);
            wr(3'd2, ~one[63:32]);
            send(a);                     expect_acc("R6", 0);
        end

        // R10 writes to unused selects change nothing
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        send(48'h0100_5E00_0001);        expect_acc("R10", 0);
        send(BC);                        expect_acc("R10", 0);
        send(STA);                       expect_acc("R10", 1);

        // R10 write in the strobe cycle does not affect that strobe
        @(negedge clk);
        da_valid = 1; da = 48'h0000_1111_2222;
        cfg_wr_en = 1; cfg_wr_sel = 3'd0; cfg_wr_data = 32'h0020_0000;
        @(negedge clk);
        da_valid = 0; cfg_wr_en = 0;
        expect_acc("R10", 0);
        // R8 promiscuous
        send(48'h0000_1111_2222);        expect_acc("R8", 1);
        send(48'h0100_5E00_0001);        expect_acc("R8", 1);

        // R2 back-to-back strobes, R9 hold
        wr(3'd0, 32'h0000_2000);
        @(negedge clk);
        da_valid = 1; da = STA;
        @(negedge clk);
        da = BC;
        @(negedge clk);
        da = 48'h0A0B_0C0D_0E0F;
        @(negedge clk);
        da_valid = 0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule